// File: doc/BRIEF.md
# Serial NOR Flash Read Master

This block is a mode-0 serial master for reading a serial NOR flash one 32-bit word at a time. The host side is a set of plain ports. Words written into a transmit FIFO are shifted out most significant bit first. Each word clocked out clocks one 32-bit word in from the flash. That word can be byte-swapped and/or half-word-swapped, and is then stored in a receive FIFO, which the host drains through a show-ahead read port.

A flash read works as follows. Software drives chip select low through a control input. It writes the command word: read opcode 0x03 in bits [31:24] and a 24-bit byte address in bits [23:0]. It then writes filler words to keep the clock running. The first received word spans the command period. Every later word carries four flash bytes. An optional packet limit stops the clock after a fixed number of words, even if the TX FIFO still holds data. Chip select stays low until software raises it.

The shifter is a four-state machine:
- `SH_IDLE` moves to `SH_LOW` when a word may start; that transition pops the TX FIFO.
- `SH_LOW` (SCLK low, MOSI presented) moves to `SH_HIGH` at the end of a half period, sampling MISO.
- `SH_HIGH` returns to `SH_LOW` at the end of a half period while bits remain, and goes to `SH_DONE` after bit 31.
- `SH_DONE` stores the received word and returns to `SH_IDLE`.
- A soft reset forces `SH_IDLE` from any state.

Top module: `spi_flash_reader`

## Requirements
- R1: Each TX word is shifted out MSB first on `mosi`. `sclk` idles low. `mosi` is stable across each rising edge of `sclk`. `miso` is sampled on the rising edge, so a word read with opcode 0x03 in bits [31:24] and address in [23:0] delivers flash bytes MSB first in later words.
- R2: One `sclk` period lasts `clk_div` system cycles (even, at least 2), and each word produces exactly 32 rising edges.
- R3: `status` holds the RX FIFO level in bits [21:15] and the TX FIFO level in bits [12:6], each a 7-bit count from 0 to 64. TX-done is bit 0 and the sticky error flag is bit 1. All other bits read 0.
- R4: With `pkt_en` high, exactly `pkt_cnt` words are shifted after the last soft reset and the clock then stops, leaving any further TX words queued. With `pkt_en` low, every queued word is shifted.
- R5: While `soft_rst` is high, both FIFOs are emptied, the shifter returns to idle, the packet progress is cleared and the error flag is cleared.
- R6: TX-done (`status[0]`) is 1 exactly when the TX FIFO is empty and no word is in flight; while it is 1, `sclk` is low.
- R7: `cs_n` follows `cs_inactive`, so chip select stays low over any number of words until software sets `cs_inactive`.
- R8: With `swap_en` high, each received word r = {b0,b1,b2,b3} (b0 first on the wire) is stored as {b1,b0,b3,b2} when only `swap_bytes` is set, {b2,b3,b0,b1} when only `swap_halves` is set, and {b3,b2,b1,b0} when both are set. With `swap_en` low, or with neither control set, the word is stored unchanged.
- R9: No word starts while `tx_on` is low, so `sclk` does not toggle. With `rx_on` low, words are still shifted out but received words are not stored.
- R10: A TX write while the TX FIFO holds 64 words, or an RX read while the RX FIFO is empty, leaves the FIFO unchanged and sets the sticky error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Channel soft reset, flushes FIFOs and progress |
| tx_on | input | 1 | Enables shifting of TX words |
| rx_on | input | 1 | Enables storing of received words |
| cs_inactive | input | 1 | Chip select inactive control (1 = CS high) |
| clk_div | input | 8 | SCLK divisor in system cycles, even, at least 2 |
| pkt_en | input | 1 | Enables the packet word limit |
| pkt_cnt | input | 16 | Number of words allowed while the limit is enabled |
| swap_en | input | 1 | Enables the RX swap stage |
| swap_bytes | input | 1 | Swap bytes within each half-word |
| swap_halves | input | 1 | Swap the two half-words |
| tx_wr_en | input | 1 | TX FIFO write strobe |
| tx_wr_data | input | 32 | TX word |
| rx_rd_en | input | 1 | RX FIFO read strobe (pops the head) |
| rx_rd_data | output | 32 | RX FIFO head word |
| status | output | 32 | Levels, TX-done and error flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| cs_n | output | 1 | Chip select, active low |

## Verification
A FIFO write or read is visible in the `status` levels in the cycle after the strobe's clock edge. The bench therefore drives strobes at falling edges and samples one falling edge later. A word takes 32 × `clk_div` + 2 cycles: one pop cycle, 64 half periods and one store cycle. The received word reaches the RX FIFO on the same edge that raises TX-done. The bench therefore polls `status[0]` at falling edges and only then reads levels and data. It measures SCLK periods from the cycle count between rising edges, and checks its expected words against a flash model that decodes the command it captures from `mosi`.

// File: rtl/spi_fr_pkg.sv
package spi_fr_pkg;

    localparam int WORD_W     = 32;
    localparam int ST_DONE    = 0;
    localparam int ST_ERR     = 1;
    localparam int ST_TXL_LSB = 6;
    localparam int ST_RXL_LSB = 15;
    localparam int ST_LVL_W   = 7;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH,
        SH_DONE
    } sh_state_e;

    // R8: byte swap within half-words, half-word swap, or both
    function automatic logic [WORD_W-1:0] rx_swap(
        input logic [WORD_W-1:0] w,
        input logic              en,
        input logic              bytes,
        input logic              halves
    );
        logic [WORD_W-1:0] t;
        t = w;
        if (en && bytes)  t = {t[23:16], t[31:24], t[7:0], t[15:8]};
        if (en && halves) t = {t[15:0], t[31:16]};
        return t;
    endfunction

endpackage

// File: rtl/spi_fr_fifo.sv
module spi_fr_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    output logic          full,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic          empty,
    output logic [LW-1:0] level
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_wr, do_rd;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_wr) wp <= wp + 1'b1;
            if (do_rd) rp <= rp + 1'b1;
            if (do_wr && !do_rd)      level <= level + 1'b1;
            else if (do_rd && !do_wr) level <= level - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

endmodule

// File: rtl/spi_fr_shifter.sv
module spi_fr_shifter
    import spi_fr_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              tx_on,
    input  logic              rx_on,
    input  logic              pkt_en,
    input  logic [CNT_W-1:0]  pkt_cnt,
    input  logic              tx_avail,
    input  logic              rx_room,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_pop,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_push,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy
);

    localparam int BIT_W = $clog2(WORD_W);

    sh_state_e         state, nxt;
    logic [WORD_W-1:0] tx_sh, rx_sh;
    logic [BIT_W-1:0]  bit_cnt;
    logic [DIV_W-1:0]  hcnt, half, half_m1;
    logic [CNT_W-1:0]  words_done;
    logic              hc_end, start;

    assign half    = clk_div >> 1;
    assign half_m1 = (half == '0) ? '0 : half - 1'b1;
    assign hc_end  = (hcnt == half_m1);
    assign start   = tx_on && tx_avail && (!rx_on || rx_room) &&
                     (!pkt_en || (words_done < pkt_cnt));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= SH_IDLE;
        else if (flush) state <= SH_IDLE;
        else            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            SH_IDLE: if (start)  nxt = SH_LOW;
            SH_LOW:  if (hc_end) nxt = SH_HIGH;
            SH_HIGH: if (hc_end) nxt = (bit_cnt == BIT_W'(WORD_W - 1)) ? SH_DONE : SH_LOW;
            SH_DONE: nxt = SH_IDLE;
            default: nxt = SH_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh      <= '0;
            rx_sh      <= '0;
            bit_cnt    <= '0;
            hcnt       <= '0;
            words_done <= '0;
        end else if (flush) begin
            bit_cnt    <= '0;
            hcnt       <= '0;
            words_done <= '0;
        end else begin
            if (state != nxt)                            hcnt <= '0;
            else if (state == SH_LOW || state == SH_HIGH) hcnt <= hcnt + 1'b1;
            if (tx_pop) tx_sh <= tx_word;
            if (state == SH_LOW && hc_end) rx_sh <= {rx_sh[WORD_W-2:0], miso};
            if (state == SH_HIGH && hc_end) begin
                tx_sh   <= tx_sh << 1;
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (state == SH_IDLE) bit_cnt <= '0;
            if (state == SH_DONE && pkt_en) words_done <= words_done + 1'b1;
        end
    end

    // outputs
    always_comb begin
        sclk    = (state == SH_HIGH);
        mosi    = (state == SH_LOW || state == SH_HIGH) ? tx_sh[WORD_W-1] : 1'b0;
        tx_pop  = (state == SH_IDLE) && start;
        rx_push = (state == SH_DONE) && rx_on;
        busy    = (state != SH_IDLE);
        rx_word = rx_sh;
    end

endmodule

// File: rtl/spi_flash_reader.sv
module spi_flash_reader
    import spi_fr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DIV_W = 8,
    parameter int CNT_W = 16,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              tx_on,
    input  logic              rx_on,
    input  logic              cs_inactive,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              pkt_en,
    input  logic [CNT_W-1:0]  pkt_cnt,
    input  logic              swap_en,
    input  logic              swap_bytes,
    input  logic              swap_halves,
    input  logic              tx_wr_en,
    input  logic [WORD_W-1:0] tx_wr_data,
    input  logic              rx_rd_en,
    output logic [WORD_W-1:0] rx_rd_data,
    output logic [31:0]       status,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);

    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [LW-1:0]     tx_lvl, rx_lvl;
    logic [WORD_W-1:0] tx_head, sh_rx_word;
    logic              tx_pop, rx_push, sh_busy, err_q;

    spi_fr_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst),
        .wr_en(tx_wr_en), .wr_data(tx_wr_data), .full(tx_full),
        .rd_en(tx_pop), .rd_data(tx_head), .empty(tx_empty), .level(tx_lvl)
    );

    spi_fr_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst),
        .wr_en(rx_push), .wr_data(rx_swap(sh_rx_word, swap_en, swap_bytes, swap_halves)),
        .full(rx_full), .rd_en(rx_rd_en), .rd_data(rx_rd_data),
        .empty(rx_empty), .level(rx_lvl)
    );

    spi_fr_shifter #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst), .clk_div(clk_div),
        .tx_on(tx_on), .rx_on(rx_on), .pkt_en(pkt_en), .pkt_cnt(pkt_cnt),
        .tx_avail(!tx_empty), .rx_room(!rx_full), .tx_word(tx_head),
        .tx_pop(tx_pop), .rx_word(sh_rx_word), .rx_push(rx_push),
        .miso(miso), .sclk(sclk), .mosi(mosi), .busy(sh_busy)
    );

    // R10: sticky misuse flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        err_q <= 1'b0;
        else if (soft_rst) err_q <= 1'b0;
        else if ((tx_wr_en && tx_full) || (rx_rd_en && rx_empty)) err_q <= 1'b1;
    end

    always_comb begin
        status = '0;
        status[ST_RXL_LSB +: ST_LVL_W] = ST_LVL_W'(rx_lvl);
        status[ST_TXL_LSB +: ST_LVL_W] = ST_LVL_W'(tx_lvl);
        status[ST_DONE] = tx_empty && !sh_busy;
        status[ST_ERR]  = err_q;
    end

    assign cs_n = cs_inactive;

endmodule

// File: rtl/spi_flash_reader_chk.sv
module spi_flash_reader_chk #(
    parameter int DEPTH = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        tx_on,
    input logic        sclk,
    input logic [31:0] status,
    input logic        busy
);

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(status[21:15]) <= DEPTH) && (32'(status[12:6]) <= DEPTH)); // R3

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (status[21:15] == 7'd0) && (status[12:6] == 7'd0) && !status[1]); // R5

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> !sclk); // R6

    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_on && !busy) |=> !sclk); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !soft_rst) |=> status[1]); // R10

endmodule

bind spi_flash_reader spi_flash_reader_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_on(tx_on),
    .sclk(sclk), .status(status), .busy(sh_busy)
);

// File: tb/spi_flash_reader_tb_top.sv
module spi_flash_reader_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0, tx_on = 1'b1, rx_on = 1'b1, cs_inactive = 1'b1;
    logic [7:0]  clk_div = 8'd2;
    logic        pkt_en = 1'b0;
    logic [15:0] pkt_cnt = 16'd0;
    logic        swap_en = 1'b0, swap_bytes = 1'b0, swap_halves = 1'b0;
    logic        tx_wr_en = 1'b0, rx_rd_en = 1'b0;
    logic [31:0] tx_wr_data = '0;
    logic [31:0] rx_rd_data, status;
    logic        sclk, mosi, miso, cs_n;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_flash_reader dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_on(tx_on), .rx_on(rx_on),
        .cs_inactive(cs_inactive), .clk_div(clk_div), .pkt_en(pkt_en), .pkt_cnt(pkt_cnt),
        .swap_en(swap_en), .swap_bytes(swap_bytes), .swap_halves(swap_halves),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .rx_rd_en(rx_rd_en),
        .rx_rd_data(rx_rd_data), .status(status), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    // ---------------- flash model and SCLK monitor ----------------
    int          cyc = 0;
    int          fl_bits = 0;
    logic [31:0] cmd_cap = '0;
    int          rises_total = 0;
    int          last_rise = -1;
    int          last_period = 0;

    always @(negedge clk) cyc++;

    function automatic logic [7:0] fmem(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic fbit(input int b, input logic [23:0] a);
        logic [7:0] m;
        if (b < 32) return 1'b0;
        m = fmem(a + 24'((b - 32) / 8));
        return m[7 - (b % 8)];
    endfunction

    assign miso = cs_n ? 1'b0 : fbit(fl_bits, cmd_cap[23:0]);

    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) fl_bits <= 0;
        else begin
            if (fl_bits < 32) cmd_cap <= {cmd_cap[30:0], mosi};
            fl_bits <= fl_bits + 1;
        end
    end

    always @(posedge sclk) begin
        rises_total++;
        if (last_rise >= 0) last_period = cyc - last_rise;
        last_rise = cyc;
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        tx_wr_en = 1'b1; tx_wr_data = w;
        @(negedge clk);
        tx_wr_en = 1'b0;
    endtask

    task automatic pop(output logic [31:0] w);
        w = rx_rd_data;
        rx_rd_en = 1'b1;
        @(negedge clk);
        rx_rd_en = 1'b0;
    endtask

    task automatic pulse_soft_rst();
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_done();
        int g = 0;
        repeat (3) @(negedge clk);
        while (!status[0] && g < 20000) begin @(negedge clk); g++; end
    endtask

    function automatic logic [31:0] exp_word(input int k, input logic [23:0] a, input int mode);
        logic [7:0] b0, b1, b2, b3;
        if (k == 0) return 32'h0;
        b0 = fmem(a + 24'(4*(k-1)));
        b1 = fmem(a + 24'(4*(k-1)+1));
        b2 = fmem(a + 24'(4*(k-1)+2));
        b3 = fmem(a + 24'(4*(k-1)+3));
        case (mode)
            1: return {b1, b0, b3, b2};
            2: return {b2, b3, b0, b1};
            3: return {b3, b2, b1, b0};
            default: return {b0, b1, b2, b3};
        endcase
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] w;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R3", "reset status", status, 32'h1);
        check("R1", "sclk idle low", sclk, 0);
        check("R7", "cs high", cs_n, 1);

        // read sweep: divisors x swap modes
        for (int d = 1; d <= 3; d++) begin
            for (int m = 0; m < 4; m++) begin
                logic [23:0] addr;
                addr = 24'h012340 + 24'(d * 64 + m * 8);
                pulse_soft_rst();
                clk_div = 8'(2 * d);
                swap_en = (m != 0); swap_bytes = m[0]; swap_halves = m[1];
                pkt_en = 1'b1; pkt_cnt = 16'd3;
                cs_inactive = 1'b0;
                @(negedge clk);
                check("R7", "cs low", cs_n, 0);
                base = rises_total;
                push({8'h03, addr});
                push(32'hFFFF_FFFF);
                push(32'hFFFF_FFFF);
                wait_done();
                check("R2", "sclk period", last_period, 2 * d);
                check("R2", "rising edges", rises_total - base, 96);
                check("R1", "captured command", cmd_cap, {8'h03, addr});
                check("R7", "cs held low", cs_n, 0);
                check("R3", "rx level", status[21:15], 3);
                cs_inactive = 1'b1;
                for (int k = 0; k < 3; k++) begin
                    pop(w);
                    check(m == 0 ? "R1" : "R8", "rx word", w, exp_word(k, addr, m));
                end
                check("R3", "rx level drained", status[21:15], 0);
            end
        end
        swap_en = 1'b0; swap_bytes = 1'b0; swap_halves = 1'b0;
        clk_div = 8'd2;

        // R4: packet limit leaves words queued
        pulse_soft_rst();
        pkt_en = 1'b1; pkt_cnt = 16'd4;
        base = rises_total;
        for (int i = 0; i < 6; i++) push(32'(i));
        repeat (400) @(negedge clk);
        check("R4", "limited edges", rises_total - base, 128);
        check("R4", "rx level", status[21:15], 4);
        check("R4", "tx left", status[12:6], 2);
        check("R6", "not done with queue", status[0], 0);

        // R5: soft reset flushes
        pulse_soft_rst();
        check("R5", "status after flush", status, 32'h1);

        // R4: limit disabled shifts all
        pkt_en = 1'b0;
        for (int i = 0; i < 5; i++) push(32'hA5A5_0000 + 32'(i));
        wait_done();
        check("R4", "unlimited rx level", status[21:15], 5);
        check("R6", "done", status[0], 1);
        pulse_soft_rst();

        // R9: rx off shifts without storing
        rx_on = 1'b0;
        base = rises_total;
        push(32'h1); push(32'h2);
        wait_done();
        check("R9", "edges rx off", rises_total - base, 64);
        check("R9", "nothing stored", status[21:15], 0);

        // R9: tx off, no clock
        tx_on = 1'b0;
        base = rises_total;
        push(32'h3); push(32'h4);
        repeat (100) @(negedge clk);
        check("R9", "no edges tx off", rises_total - base, 0);
        check("R9", "tx queued", status[12:6], 2);
        check("R6", "not done", status[0], 0);

        // R10: underflow then overflow
        w = status;
        pop(w);
        check("R10", "underflow err", status[1], 1);
        check("R10", "rx level kept", status[21:15], 0);
        pulse_soft_rst();
        for (int i = 0; i < DEPTH; i++) push(32'(i));
        check("R10", "full level", status[12:6], 64);
        check("R10", "no err yet", status[1], 0);
        push(32'hDEAD);
        check("R10", "overflow err", status[1], 1);
        check("R10", "level kept", status[12:6], 64);
        pulse_soft_rst();
        check("R5", "err cleared", status[1], 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule